// File: doc/BRIEF.md
# Indexed Block Configuration Target on a Two-Wire Serial Bus

This block is a target on a two-wire serial management bus. It serves a bank of eight 8-bit configuration bytes that a clock-distribution core reads continuously. The block samples SCL and SDA with its own faster system clock and drives SDA open-drain by pulling it low. The whole bank is presented in parallel on `reg_image`, so downstream logic never waits on the bus.

A host writes by sending the 7-bit address 0x6E with the direction bit clear (byte 0xDC), then a starting index and a byte count, then that many data bytes. A host reads by sending 0xDC and the index, then a repeated start and 0xDD. The target answers with the content of its byte-count register, followed by data bytes from the index onward. The host acknowledges every byte except the last one, which it refuses, and then issues a stop. Byte 6 is the byte-count register: it limits how many data bytes a read returns. Bytes 4 and 5 are fixed identification values.

The controller is one state machine:
- IDLE and IGNORE wait for a start condition.
- ADDR, INDEX, COUNT and WDATA each shift in one byte.
- Each of those four has a matching acknowledge state: ADDR_ACK, INDEX_ACK, COUNT_ACK and WDATA_ACK.
- TX shifts out one byte.
- TX_ACK samples the host's answer.

The transitions are as follows:
- A start goes from any state to ADDR, and a stop goes from any state to IDLE.
- ADDR goes to ADDR_ACK on an address match, or to IGNORE otherwise.
- After ADDR_ACK, a read goes to TX and a write goes to INDEX.
- INDEX goes through INDEX_ACK to COUNT, and COUNT goes through COUNT_ACK to WDATA.
- WDATA loops through WDATA_ACK back to WDATA.
- TX goes to TX_ACK. TX_ACK returns to TX when the host acknowledges, or goes to IGNORE when it refuses.

Top module: `smb_cfg_target`

## Requirements
- R1: After reset, the bytes at indices 0 to 7 are 0x07, 0xFF, 0x00, 0x00, 0x21, 0x83, 0x07 and 0x00. Byte i appears on `reg_image[8i+7:8i]`, and `sda_oe` is 0.
- R2: An address byte of 0xDC (write) or 0xDD (read) is acknowledged. The target holds SDA low through the ninth clock.
- R3: The target does not acknowledge any other address byte. It leaves SDA released, and it ignores all following bytes until the next start, so no register changes.
- R4: A write of index N, count X and X data bytes stores those bytes at indices N to N+X-1. The target acknowledges the index, the count and every stored byte.
- R5: Data bytes beyond the count are not acknowledged and are not stored. A count of 0 stores nothing.
- R6: Writes to index 4 (revision in bits 7:4, vendor 0001 in bits 3:0) and index 5 (device ID 0x83) are acknowledged but leave both bytes unchanged.
- R7: A read sends the byte-count register first and then the bytes from the index onward, most significant bit first.
- R8: A read returns as many data bytes as byte 6 holds. Further bytes that the host acknowledges read as 0xFF.
- R9: The index uses the low three bits of the index byte and wraps from 7 to 0 during a transfer.
- R10: A stop in the middle of a write ends the transfer. Bytes already stored are kept, and a later transaction works normally.
- R11: A repeated start after the index byte begins a read at that index.
- R12: The target changes `sda_oe` only while SCL is low.
- R13: After the host refuses a read byte, the target releases SDA until a stop or a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_image | output | 64 | All eight configuration bytes, byte i at bits 8i+7:8i |

## Verification
The hardest situation to reach is a read that runs past the programmed count. Getting there takes three transactions in a row: the byte-count register is first rewritten to a small value, then a read is started with an index byte whose upper bits are set, and finally the host keeps acknowledging after the counted bytes. That sequence shows the count limit, the index wrap and the 0xFF filler together. A second hard case is the release after the host refuses a byte. The host clocks one more bit after the refusal and must see SDA high, which would not happen if the target went on sending the next byte. A stop placed right after the first data byte of a three-byte write covers the abort path.

// File: rtl/smb_pkg.sv
package smb_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_INDEX,
        S_INDEX_ACK,
        S_COUNT,
        S_COUNT_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_TX,
        S_TX_ACK,
        S_IGNORE
    } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              q_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain  <= '1;
            q_prev <= 1'b1;
        end else begin
            chain  <= {chain[STAGES-2:0], d};
            q_prev <= chain[STAGES-1];
        end
    end

    assign q    = chain[STAGES-1];
    assign rise = q & ~q_prev;
    assign fall = ~q & q_prev;
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
    parameter int         NUM_REGS  = 8,
    parameter int         ID_REG    = 4,
    parameter int         DEVID_REG = 5,
    parameter logic [3:0] REV_ID    = 4'h2,
    parameter logic [7:0] DEV_ID    = 8'h83,
    localparam int        IW        = $clog2(NUM_REGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [IW-1:0]         waddr,
    input  logic [7:0]            wdata,
    input  logic [IW-1:0]         raddr,
    output logic [7:0]            rdata,
    output logic [NUM_REGS*8-1:0] image
);
    function automatic logic [7:0] init_of(int i);
        case (i)
            0:         return 8'h07;
            1:         return 8'hFF;
            6:         return 8'h07;
            ID_REG:    return {REV_ID, 4'b0001};
            DEVID_REG: return DEV_ID;
            default:   return 8'h00;
        endcase
    endfunction

    logic [7:0] bank [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
        localparam logic [7:0] INIT = init_of(g);
        if (g == ID_REG || g == DEVID_REG) begin : g_fixed
            assign bank[g] = INIT;
        end else begin : g_store
            logic [7:0] val;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    val <= INIT;
                else if (we && waddr == IW'(g))
                    val <= wdata;
            end
            assign bank[g] = val;
        end
        assign image[g*8 +: 8] = bank[g];
    end

    assign rdata = bank[raddr];
endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target
    import smb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h6E,
    parameter int         NUM_REGS    = 8,
    parameter int         COUNT_REG   = 6,
    parameter logic [3:0] REV_ID      = 4'h2,
    parameter logic [7:0] DEV_ID      = 8'h83,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] reg_image
);
    localparam int            IW      = $clog2(NUM_REGS);
    localparam logic [IW-1:0] IDX_ONE = 1;

    logic scl_s, scl_r, scl_f;
    logic sda_s, sda_r, sda_f;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s), .rise(scl_r), .fall(scl_f)
    );
    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s), .rise(sda_r), .fall(sda_f)
    );

    logic ev_start, ev_stop;
    assign ev_start = sda_f & scl_s;
    assign ev_stop  = sda_r & scl_s;

    smb_state_e       state, state_nx;
    logic [6:0]       rx_sh;
    logic [7:0]       rx_byte;
    logic [3:0]       bitcnt;
    logic             drv;
    logic             ack_ok;
    logic             rd_dir;
    logic [IW-1:0]    idx;
    logic [7:0]       wr_left;
    logic [7:0]       rd_left;
    logic [7:0]       tx_sh;
    logic [7:0]       rd_data;
    logic [7:0]       count_val;
    logic             byte_done;
    logic             ack_end;
    logic             reg_we;

    assign rx_byte   = {rx_sh, sda_s};
    assign byte_done = scl_r && (bitcnt == 4'd7);
    assign ack_end   = scl_f && drv;
    assign count_val = reg_image[COUNT_REG*8 +: 8];
    assign reg_we    = (state == S_WDATA) && byte_done && (wr_left != 8'd0)
                       && !ev_start && !ev_stop;

    smb_regbank #(
        .NUM_REGS(NUM_REGS), .ID_REG(4), .DEVID_REG(5),
        .REV_ID(REV_ID), .DEV_ID(DEV_ID)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(idx), .wdata(rx_byte),
        .raddr(idx), .rdata(rd_data), .image(reg_image)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        if (ev_stop)
            state_nx = S_IDLE;
        else if (ev_start)
            state_nx = S_ADDR;
        else begin
            unique case (state)
                S_IDLE, S_IGNORE: state_nx = state;
                S_ADDR:      if (byte_done) state_nx = (rx_byte[7:1] == DEV_ADDR) ? S_ADDR_ACK : S_IGNORE;
                S_INDEX:     if (byte_done) state_nx = S_INDEX_ACK;
                S_COUNT:     if (byte_done) state_nx = S_COUNT_ACK;
                S_WDATA:     if (byte_done) state_nx = S_WDATA_ACK;
                S_ADDR_ACK:  if (ack_end) state_nx = rd_dir ? S_TX : S_INDEX;
                S_INDEX_ACK: if (ack_end) state_nx = S_COUNT;
                S_COUNT_ACK: if (ack_end) state_nx = S_WDATA;
                S_WDATA_ACK: if (ack_end) state_nx = S_WDATA;
                S_TX:        if (scl_f && bitcnt == 4'd8) state_nx = S_TX_ACK;
                S_TX_ACK: begin
                    if (scl_r && sda_s)    state_nx = S_IGNORE;
                    else if (scl_f && drv) state_nx = S_TX;
                end
                default: state_nx = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh   <= '0;
            bitcnt  <= '0;
            drv     <= 1'b0;
            ack_ok  <= 1'b0;
            rd_dir  <= 1'b0;
            idx     <= '0;
            wr_left <= '0;
            rd_left <= '0;
            tx_sh   <= 8'hFF;
        end else if (ev_start || ev_stop) begin
            bitcnt <= '0;
            drv    <= 1'b0;
            ack_ok <= 1'b0;
        end else begin
            case (state)
                S_ADDR, S_INDEX, S_COUNT, S_WDATA: begin
                    if (scl_r) begin
                        rx_sh  <= rx_byte[6:0];
                        bitcnt <= (bitcnt == 4'd7) ? 4'd0 : bitcnt + 4'd1;
                        if (bitcnt == 4'd7) begin
                            drv    <= 1'b0;
                            ack_ok <= 1'b1;
                            if (state == S_ADDR)  rd_dir  <= rx_byte[0];
                            if (state == S_INDEX) idx     <= rx_byte[IW-1:0];
                            if (state == S_COUNT) wr_left <= rx_byte;
                            if (state == S_WDATA) begin
                                if (wr_left != 8'd0) begin
                                    idx     <= idx + IDX_ONE;
                                    wr_left <= wr_left - 8'd1;
                                end else begin
                                    ack_ok <= 1'b0;
                                end
                            end
                        end
                    end
                end
                S_ADDR_ACK, S_INDEX_ACK, S_COUNT_ACK, S_WDATA_ACK: begin
                    if (scl_f) begin
                        drv <= ~drv;
                        if (drv && state == S_ADDR_ACK && rd_dir) begin
                            tx_sh   <= count_val;
                            rd_left <= count_val;
                            bitcnt  <= '0;
                        end
                    end
                end
                S_TX: begin
                    if (scl_r) bitcnt <= bitcnt + 4'd1;
                    if (scl_f) begin
                        if (bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            drv    <= 1'b0;
                        end else begin
                            tx_sh <= {tx_sh[6:0], 1'b1};
                        end
                    end
                end
                S_TX_ACK: begin
                    if (scl_r && !sda_s) drv <= 1'b1;
                    if (scl_f && drv) begin
                        drv <= 1'b0;
                        if (rd_left != 8'd0) begin
                            tx_sh   <= rd_data;
                            idx     <= idx + IDX_ONE;
                            rd_left <= rd_left - 8'd1;
                        end else begin
                            tx_sh <= 8'hFF;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            S_ADDR_ACK, S_INDEX_ACK, S_COUNT_ACK, S_WDATA_ACK: sda_oe = drv & ack_ok;
            S_TX:    sda_oe = ~tx_sh[7];
            default: sda_oe = 1'b0;
        endcase
    end

    assert_sda_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s)
        else $error("sda_oe changed while SCL high");

    assert_store_after_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_image) |-> $past(state) == S_WDATA)
        else $error("register bank changed outside a data byte");

    assert_ignore_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_IGNORE && state != S_IGNORE) |-> (state == S_ADDR || state == S_IDLE))
        else $error("left ignore state without start or stop");

    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> state == S_IDLE)
        else $error("stop did not return to idle");

    assert_tx_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_TX |-> bitcnt <= 4'd8)
        else $error("transmit bit counter overran");
endmodule

// File: tb/smb_cfg_target_bench.sv
module smb_cfg_target_bench;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        scl_h;
    logic        sda_h;
    logic        sda_oe;
    logic        sda_line;
    logic [63:0] img;
    int          checks = 0;
    int          errors = 0;
    int          r12_viol = 0;
    logic        oe_prev = 1'b0;
    logic        done = 1'b0;
    logic [7:0]  exp_img [8];

    always #4 clk = ~clk;

    assign sda_line = sda_h & ~sda_oe;

    smb_cfg_target u_smb_cfg_target (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_h), .sda_in(sda_line),
        .sda_oe(sda_oe), .reg_image(img)
    );

    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl_h) r12_viol++;
        oe_prev <= sda_oe;
    end

    task automatic tq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_image(input string tag);
        for (int i = 0; i < 8; i++) chk(tag, img[i*8 +: 8], exp_img[i]);
    endtask

    task automatic bit_out(input logic b);
        sda_h = b; tq(); scl_h = 1'b1; tq(); tq(); scl_h = 1'b0; tq();
    endtask

    task automatic bit_in(output logic b);
        sda_h = 1'b1; tq(); scl_h = 1'b1; tq(); b = sda_line; tq(); scl_h = 1'b0; tq();
    endtask

    task automatic start_c();
        sda_h = 1'b1; tq(); scl_h = 1'b1; tq(); sda_h = 1'b0; tq(); scl_h = 1'b0; tq();
    endtask

    task automatic stop_c();
        sda_h = 1'b0; tq(); scl_h = 1'b1; tq(); sda_h = 1'b1; tq(); tq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(s);
        ack = ~s;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_in(s);
            b[i] = s;
        end
        bit_out(~give_ack);
    endtask

    task automatic t_reset();
        exp_img = '{8'h07, 8'hFF, 8'h00, 8'h00, 8'h21, 8'h83, 8'h07, 8'h00};
        check_image("R1 reset image");
        chk("R1 sda released", {7'd0, sda_oe}, 8'h00);
    endtask

    task automatic t_write_read();
        logic a;
        logic [7:0] d;
        logic [7:0] wr [3] = '{8'hA5, 8'h3C, 8'h81};
        logic [7:0] rd_exp [8] = '{8'h07, 8'hA5, 8'h3C, 8'h81, 8'h21, 8'h83, 8'h07, 8'h00};
        start_c();
        send_byte(8'hDC, a); chk("R2 write address ack", {7'd0, a}, 8'h01);
        send_byte(8'h01, a); chk("R4 index ack", {7'd0, a}, 8'h01);
        send_byte(8'h03, a); chk("R4 count ack", {7'd0, a}, 8'h01);
        for (int i = 0; i < 3; i++) begin
            send_byte(wr[i], a); chk("R4 data ack", {7'd0, a}, 8'h01);
            exp_img[1+i] = wr[i];
        end
        stop_c();
        check_image("R4 stored block");
        start_c();
        send_byte(8'hDC, a);
        send_byte(8'h01, a);
        start_c();
        send_byte(8'hDD, a); chk("R2 R11 read address ack", {7'd0, a}, 8'h01);
        for (int i = 0; i < 8; i++) begin
            recv_byte(d, i != 7);
            chk("R7 read sequence", d, rd_exp[i]);
        end
        stop_c();
    endtask

    task automatic t_readonly();
        logic a;
        start_c();
        send_byte(8'hDC, a);
        send_byte(8'h04, a);
        send_byte(8'h02, a);
        send_byte(8'h00, a); chk("R6 id byte write ack", {7'd0, a}, 8'h01);
        send_byte(8'h00, a); chk("R6 device byte write ack", {7'd0, a}, 8'h01);
        stop_c();
        check_image("R6 fixed bytes unchanged");
    endtask

    task automatic t_overcount();
        logic a;
        logic [7:0] dat [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
        logic [7:0] ack_exp [4] = '{8'h01, 8'h01, 8'h00, 8'h00};
        start_c();
        send_byte(8'hDC, a);
        send_byte(8'h07, a);
        send_byte(8'h02, a);
        for (int i = 0; i < 4; i++) begin
            send_byte(dat[i], a); chk("R5 ack within count only", {7'd0, a}, ack_exp[i]);
        end
        stop_c();
        exp_img[7] = 8'h11;
        exp_img[0] = 8'h22;
        check_image("R9 R5 wrap and count limit");
        start_c();
        send_byte(8'hDC, a);
        send_byte(8'h03, a);
        send_byte(8'h00, a);
        send_byte(8'h5A, a); chk("R5 zero count nack", {7'd0, a}, 8'h00);
        stop_c();
        check_image("R5 zero count stores nothing");
    endtask

    task automatic t_bad_addr();
        logic a;
        start_c();
        send_byte(8'hA0, a); chk("R3 foreign address nack", {7'd0, a}, 8'h00);
        send_byte(8'h00, a); chk("R3 later byte nack", {7'd0, a}, 8'h00);
        send_byte(8'h01, a);
        send_byte(8'hEE, a); chk("R3 data nack", {7'd0, a}, 8'h00);
        stop_c();
        check_image("R3 bank unchanged");
    endtask

    task automatic t_count_reg();
        logic a;
        logic [7:0] d;
        logic [7:0] rd_exp [4] = '{8'h02, 8'h81, 8'h21, 8'hFF};
        start_c();
        send_byte(8'hDC, a);
        send_byte(8'h06, a);
        send_byte(8'h01, a);
        send_byte(8'h02, a); chk("R8 count register write ack", {7'd0, a}, 8'h01);
        stop_c();
        exp_img[6] = 8'h02;
        check_image("R8 count register stored");
        start_c();
        send_byte(8'hDC, a);
        send_byte(8'h0B, a);
        start_c();
        send_byte(8'hDD, a); chk("R11 read after repeated start", {7'd0, a}, 8'h01);
        for (int i = 0; i < 4; i++) begin
            recv_byte(d, i != 3);
            chk("R8 R9 limited read", d, rd_exp[i]);
        end
        stop_c();
    endtask

    task automatic t_abort();
        logic a;
        start_c();
        send_byte(8'hDC, a);
        send_byte(8'h02, a);
        send_byte(8'h03, a);
        send_byte(8'h99, a);
        stop_c();
        exp_img[2] = 8'h99;
        check_image("R10 stored byte kept after stop");
        start_c();
        send_byte(8'hDC, a); chk("R10 next transaction ack", {7'd0, a}, 8'h01);
        send_byte(8'h03, a);
        send_byte(8'h01, a);
        send_byte(8'h44, a);
        stop_c();
        exp_img[3] = 8'h44;
        check_image("R10 later write works");
    endtask

    task automatic t_nack();
        logic a;
        logic [7:0] d;
        logic s;
        start_c();
        send_byte(8'hDC, a);
        send_byte(8'h00, a);
        start_c();
        send_byte(8'hDD, a);
        recv_byte(d, 1'b0);
        chk("R7 count byte", d, 8'h02);
        bit_in(s);
        chk("R13 released after refusal", {7'd0, s}, 8'h01);
        stop_c();
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all requirements actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0;
        scl_h = 1'b1;
        sda_h = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_write_read();
        t_readonly();
        t_overcount();
        t_bad_addr();
        t_count_reg();
        t_abort();
        t_nack();
        checks++;
        if (r12_viol != 0) begin
            errors++;
            $display("FAIL R12 sda_oe changes with SCL high actual %0d expected 0", r12_viol);
        end
        done = 1'b1;
        finish_run();
    end
endmodule